// File: doc/BRIEF.md
# Three-Phase Sine PWM Sequencer

This block produces the duty-cycle references for a three-phase inverter. It holds a single table with one full period of a raised cosine, sampled at 240 points. It also keeps one shared phase pointer. Each zero event from the external carrier counter moves the pointer one step. The block then loads three new compare values, one for each output phase, into registered outputs. The three phases read the same table at positions one third of a period apart, so the phases are 120 degrees apart. A full electrical cycle therefore takes 240 carrier periods.

Each phase drives two comparator outputs that always carry the same value, so it can feed a pair of complementary comparators directly. A one-cycle strobe marks every update. When the enable input is low, the pointer and the outputs are frozen and zero events are ignored. The table is computed during elaboration from the midpoint and swing parameters, so no value list is stored in the source.

Top module: `spwm_seq3`

## Requirements
- R1: Table entry i equals round(3125 - 3100*cos(2*pi*i/240)), so every value lies between 25 and 6225. The minimum is 25 at entry 0 and the peak is 6225 at entry 120.
- R2: The phase pointer steps by one for each accepted zero event, and goes from 239 back to 0. The 241st accepted update after reset therefore presents entry 0 again.
- R3: On an update, phase A shows the entry at the pointer, phase B shows the entry at (pointer+160) mod 240, and phase C shows the entry at (pointer+80) mod 240. The value shown is the pointer before its step.
- R4: The two comparator outputs of a phase are always equal.
- R5: A zero event sampled with the enable high at a rising edge gives new compare values and upd_stb=1 in the cycle right after that edge. upd_stb is 1 for exactly that one cycle per accepted event.
- R6: While the enable is low, zero events have no effect: the outputs keep their values, upd_stb stays 0, and the pointer does not move. The next enabled update therefore continues from where the sequence stopped.
- R7: A synchronous active-low reset sets all compare outputs to 0, sets upd_stb to 0 and sets the pointer to 0. The first update after reset shows 25 on phase A and 4675 on phases B and C.
- R8: Zero events in consecutive cycles are each accepted, and each advances the pointer once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Sequencer enable |
| zero_evt | input | 1 | Carrier-counter zero event, one per high cycle |
| pha_cmp_a | output | 16 | Phase A, first comparator value |
| pha_cmp_b | output | 16 | Phase A, second comparator value |
| phb_cmp_a | output | 16 | Phase B, first comparator value |
| phb_cmp_b | output | 16 | Phase B, second comparator value |
| phc_cmp_a | output | 16 | Phase C, first comparator value |
| phc_cmp_b | output | 16 | Phase C, second comparator value |
| upd_stb | output | 1 | One-cycle marker of a compare update |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples `zero_evt` and `en`. This holds for the new compare values, the strobe, the held values when the enable is low, and the cleared state after reset. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, which is one rising edge later. A reference pointer is advanced in step with the stimulus. The expected values come from the cosine formula at that pointer and at its two offsets. The bench therefore never reads outputs in the same delta as the edge that changes them.

// File: rtl/spwm_seq_pkg.sv
// Package: shared constants and elaboration-time helpers for the
// three-phase sine PWM sequencer.
// Assumes: helpers are only called with constant arguments.
package spwm_seq_pkg;

    localparam int NUM_PH = 3;

    typedef enum int {
        PH_A = 0,
        PH_B = 1,
        PH_C = 2
    } phase_e;

    // Table sample: midpoint minus swing times cosine, rounded to nearest.
    function automatic int sine_sample(input int idx, input int len,
                                       input int mid, input int swing);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979 * real'(idx) / real'(len);
        val = real'(mid) - real'(swing) * $cos(ang);
        return int'($floor(val + 0.5));
    endfunction

    // Table offset that each phase adds to the shared pointer.
    function automatic int phase_offset(input int ph, input int len);
        case (ph)
            PH_B:    return (2 * len) / 3;
            PH_C:    return len / 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/spwm_phase_index.sv
// Module: shared phase pointer.
// Moves by one for each accepted event and goes from LEN-1 back to 0.
// Assumes: adv is already qualified with the enable.
module spwm_phase_index #(
    parameter int LEN = 240,
    parameter int AW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(LEN - 1);

    // Pointer register: clear on reset, step with wrap on each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/spwm_idx_offset.sv
// Module: adds a fixed phase offset to the pointer, modulo the table length.
// Assumes: idx < LEN and OFFSET < LEN, so one conditional subtract is enough.
module spwm_idx_offset #(
    parameter int LEN    = 240,
    parameter int AW     = $clog2(LEN),
    parameter int OFFSET = 0
) (
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam logic [AW:0] OFF_W = (AW+1)'(OFFSET);
    localparam logic [AW:0] LEN_W = (AW+1)'(LEN);

    logic [AW:0] sum;

    // Offset add with a single wrap correction.
    always_comb begin
        sum  = {1'b0, idx} + OFF_W;
        addr = (sum >= LEN_W) ? AW'(sum - LEN_W) : AW'(sum);
    end
endmodule

// File: rtl/spwm_sine_rom.sv
// Module: sine table with NRD independent combinational read ports.
// The contents are computed at elaboration from MID and SWING.
// Assumes: addresses are below LEN; MID+SWING fits in W bits.
module spwm_sine_rom #(
    parameter int LEN   = 240,
    parameter int AW    = $clog2(LEN),
    parameter int W     = 16,
    parameter int MID   = 3125,
    parameter int SWING = 3100,
    parameter int NRD   = 3
) (
    input  logic [AW-1:0] rd_addr [NRD],
    output logic [W-1:0]  rd_data [NRD]
);
    logic [W-1:0] table_q [LEN];

    // One constant per entry, computed at elaboration.
    for (genvar e = 0; e < LEN; e++) begin : g_entry
        localparam int SAMPLE = spwm_seq_pkg::sine_sample(e, LEN, MID, SWING);
        assign table_q[e] = W'(SAMPLE);
    end

    // One read multiplexer per port.
    for (genvar r = 0; r < NRD; r++) begin : g_port
        always_comb begin
            rd_data[r] = table_q[rd_addr[r]];
        end
    end
endmodule

// File: rtl/spwm_cmp_out.sv
// Module: registered compare outputs plus the update strobe.
// Loads all phases together and pulses stb for one cycle per load.
// Assumes: load is the accepted-event pulse.
module spwm_cmp_out #(
    parameter int W   = 16,
    parameter int NPH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din [NPH],
    output logic [W-1:0] q   [NPH],
    output logic         stb
);
    // Per-phase hold register: cleared on reset, written on load.
    for (genvar p = 0; p < NPH; p++) begin : g_ph
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[p] <= '0;
            end else if (load) begin
                q[p] <= din[p];
            end
        end
    end

    // Strobe register: follows load, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb <= 1'b0;
        end else begin
            stb <= load;
        end
    end
endmodule

// File: rtl/spwm_seq3.sv
// Module: three-phase sine PWM sequencer (top).
// On each enabled carrier zero event, loads three compare values that are
// one third of a period apart, then steps the shared pointer.
// Assumes: zero_evt comes from the carrier counter in the clk domain.
module spwm_seq3 #(
    parameter int LEN   = 240,
    parameter int W     = 16,
    parameter int MID   = 3125,
    parameter int SWING = 3100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         zero_evt,
    output logic [W-1:0] pha_cmp_a,
    output logic [W-1:0] pha_cmp_b,
    output logic [W-1:0] phb_cmp_a,
    output logic [W-1:0] phb_cmp_b,
    output logic [W-1:0] phc_cmp_a,
    output logic [W-1:0] phc_cmp_b,
    output logic         upd_stb
);
    import spwm_seq_pkg::*;

    localparam int AW = $clog2(LEN);

    logic          adv;
    logic [AW-1:0] phase_idx;
    logic [AW-1:0] tap_addr [NUM_PH];
    logic [W-1:0]  tap_val  [NUM_PH];
    logic [W-1:0]  cmp_q    [NUM_PH];

    // Accept an event only while enabled.
    always_comb begin
        adv = en & zero_evt;
    end

    spwm_phase_index #(.LEN(LEN), .AW(AW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .idx   (phase_idx)
    );

    // One offset adder per phase.
    for (genvar p = 0; p < NUM_PH; p++) begin : g_tap
        spwm_idx_offset #(
            .LEN    (LEN),
            .AW     (AW),
            .OFFSET (phase_offset(p, LEN))
        ) u_off (
            .idx  (phase_idx),
            .addr (tap_addr[p])
        );
    end

    spwm_sine_rom #(
        .LEN   (LEN),
        .AW    (AW),
        .W     (W),
        .MID   (MID),
        .SWING (SWING),
        .NRD   (NUM_PH)
    ) u_rom (
        .rd_addr (tap_addr),
        .rd_data (tap_val)
    );

    spwm_cmp_out #(.W(W), .NPH(NUM_PH)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (adv),
        .din   (tap_val),
        .q     (cmp_q),
        .stb   (upd_stb)
    );

    // Both comparators of a phase take the same register.
    always_comb begin
        pha_cmp_a = cmp_q[PH_A];
        pha_cmp_b = cmp_q[PH_A];
        phb_cmp_a = cmp_q[PH_B];
        phb_cmp_b = cmp_q[PH_B];
        phc_cmp_a = cmp_q[PH_C];
        phc_cmp_b = cmp_q[PH_C];
    end
endmodule

// File: rtl/spwm_seq3_chk.sv
// Checker: temporal properties of the sequencer, bound to the top module.
// Assumes: the same parameter values as the bound instance.
module spwm_seq3_chk #(
    parameter int LEN   = 240,
    parameter int W     = 16,
    parameter int MID   = 3125,
    parameter int SWING = 3100,
    parameter int AW    = $clog2(LEN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          zero_evt,
    input logic [AW-1:0] phase_idx,
    input logic [W-1:0]  pha_cmp_a,
    input logic [W-1:0]  pha_cmp_b,
    input logic [W-1:0]  phb_cmp_a,
    input logic [W-1:0]  phb_cmp_b,
    input logic [W-1:0]  phc_cmp_a,
    input logic [W-1:0]  phc_cmp_b,
    input logic          upd_stb
);
    logic seen_upd;
    int   bal_sum;

    // Records that at least one update has loaded real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_upd <= 1'b0;
        else if (upd_stb) seen_upd <= 1'b1;
    end

    // Sum of the three phases, for the balance check.
    always_comb begin
        bal_sum = int'(pha_cmp_a) + int'(phb_cmp_a) + int'(phc_cmp_a) - 3 * MID;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && zero_evt) |=> (phase_idx == (($past(phase_idx) == AW'(LEN - 1))
                                            ? '0 : $past(phase_idx) + 1'b1)));

    p_hold_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && zero_evt) |=> $stable(phase_idx));

    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pha_cmp_a == pha_cmp_b) && (phb_cmp_a == phb_cmp_b) && (phc_cmp_a == phc_cmp_b));

    p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && zero_evt) |=> upd_stb);

    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && zero_evt) |=> (!upd_stb && $stable(pha_cmp_a)
                               && $stable(phb_cmp_a) && $stable(phc_cmp_a)));

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_upd |-> (int'(pha_cmp_a) >= MID - SWING && int'(pha_cmp_a) <= MID + SWING
                   && int'(phb_cmp_a) >= MID - SWING && int'(phb_cmp_a) <= MID + SWING
                   && int'(phc_cmp_a) >= MID - SWING && int'(phc_cmp_a) <= MID + SWING));

    p_balance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_upd |-> (bal_sum <= 2 && bal_sum >= -2));
endmodule

bind spwm_seq3 spwm_seq3_chk #(
    .LEN   (LEN),
    .W     (W),
    .MID   (MID),
    .SWING (SWING)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .zero_evt  (zero_evt),
    .phase_idx (phase_idx),
    .pha_cmp_a (pha_cmp_a),
    .pha_cmp_b (pha_cmp_b),
    .phb_cmp_a (phb_cmp_a),
    .phb_cmp_b (phb_cmp_b),
    .phc_cmp_a (phc_cmp_a),
    .phc_cmp_b (phc_cmp_b),
    .upd_stb   (upd_stb)
);

// File: tb/spwm_seq3_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random enable/event traffic,
// checked against a reference pointer and the cosine formula.
module spwm_seq3_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        zero_evt = 1'b0;
    logic [15:0] pha_cmp_a, pha_cmp_b, phb_cmp_a, phb_cmp_b, phc_cmp_a, phc_cmp_b;
    logic        upd_stb;

    int n_chk = 0;
    int n_bad = 0;
    int m_idx = 0;
    int e_a = 0, e_b = 0, e_c = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spwm_seq3 u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .zero_evt(zero_evt),
        .pha_cmp_a(pha_cmp_a), .pha_cmp_b(pha_cmp_b),
        .phb_cmp_a(phb_cmp_a), .phb_cmp_b(phb_cmp_b),
        .phc_cmp_a(phc_cmp_a), .phc_cmp_b(phc_cmp_b),
        .upd_stb(upd_stb)
    );

    // Reference sample from the R1 formula.
    function automatic int ref_entry(input int i);
        real v;
        v = 3125.0 - 3100.0 * $cos(2.0 * 3.14159265358979 * real'(i) / 240.0);
        return int'($floor(v + 0.5));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic cyc(input bit e, input bit z);
        bit upd;
        upd = e && z;
        en = e;
        zero_evt = z;
        if (upd) begin
            e_a = ref_entry(m_idx);
            e_b = ref_entry((m_idx + 160) % 240);
            e_c = ref_entry((m_idx + 80) % 240);
            m_idx = (m_idx + 1) % 240;
        end
        @(negedge clk);
        chk(upd ? "R5 strobe on update" : "R6 no strobe", int'(upd_stb), int'(upd));
        chk(upd ? "R3 phase A" : "R6 hold phase A", int'(pha_cmp_a), e_a);
        chk(upd ? "R3 phase B" : "R6 hold phase B", int'(phb_cmp_a), e_b);
        chk(upd ? "R3 phase C" : "R6 hold phase C", int'(phc_cmp_a), e_c);
        chk("R4 pair A", int'(pha_cmp_b), int'(pha_cmp_a));
        chk("R4 pair B", int'(phb_cmp_b), int'(phb_cmp_a));
        chk("R4 pair C", int'(phc_cmp_b), int'(phc_cmp_a));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 1'b0;
        zero_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_idx = 0;
        e_a = 0; e_b = 0; e_c = 0;
        chk("R7 reset A", int'(pha_cmp_a), 0);
        chk("R7 reset B", int'(phb_cmp_b), 0);
        chk("R7 reset C", int'(phc_cmp_a), 0);
        chk("R7 reset strobe", int'(upd_stb), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        @(negedge clk);
        do_reset();

        // R7: first values after reset.
        cyc(1'b1, 1'b1);
        chk("R7 first A", int'(pha_cmp_a), 25);
        chk("R7 first B", int'(phb_cmp_a), 4675);
        chk("R7 first C", int'(phc_cmp_a), 4675);
        repeat (3) cyc(1'b1, 1'b0);

        // R6: events ignored while disabled, then sequence resumes at entry 1.
        repeat (5) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R6 resume A", int'(pha_cmp_a), ref_entry(1));

        // R8: back-to-back events each advance.
        repeat (10) cyc(1'b1, 1'b1);
        chk("R8 consecutive A", int'(pha_cmp_a), ref_entry(11));

        // R1 peak and R2 wrap over a full cycle from reset.
        do_reset();
        for (int k = 0; k < 121; k++) begin
            cyc(1'b1, 1'b1);
            if (k % 7 == 0) cyc(1'b1, 1'b0);
        end
        chk("R1 peak A", int'(pha_cmp_a), 6225);
        repeat (119) cyc(1'b1, 1'b1);
        chk("R2 last A", int'(pha_cmp_a), ref_entry(239));
        cyc(1'b1, 1'b1);
        chk("R2 wrap A", int'(pha_cmp_a), 25);
        chk("R1 minimum A", int'(pha_cmp_a), 25);

        // Random traffic.
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom % 4) != 0, ($urandom % 3) == 0);
        end

        // R7: mid-run reset restarts the sequence.
        do_reset();
        cyc(1'b1, 1'b1);
        chk("R7 restart A", int'(pha_cmp_a), 25);
        chk("R7 restart B", int'(phb_cmp_a), 4675);

        finish_run();
    end
endmodule